// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Unit

This block keeps the pending-event flags and the per-source enable bits for one
8-bit timer that produces three kinds of event: a match on compare channel A, a
match on compare channel B, and a counter overflow. The timer core reports the
two compare matches as one-cycle pulses. It also exposes its count, its step
strobe and its direction, so that the block can find the overflow event itself.
The block combines each flag with its enable bit and a global interrupt-enable
input to drive one interrupt request line per source.

Software reaches the two registers through a small port: a one-bit register
select, a write strobe, write data and combinational read data. Select 0 is the
flag register and select 1 is the enable register. A flag is cleared in one of
two ways. Software writes a one to its bit, or the interrupt controller pulses
the acknowledge line of that source when the handler vector is taken.

The overflow event depends on the waveform mode input. In up-counting modes the
flag is raised when the counter steps from its all-ones value to zero. In
phase-correct mode it is raised when the counter steps down onto zero. The
turn-around at the top of the count does not raise it.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset both registers read 0x00 and no interrupt request is asserted.
- R2: The flags sit in the flag register (select 0) at these positions: overflow at bit 1, compare A at bit 2, compare B at bit 3. An event raises its flag in the clock edge that samples the event, and the flag is readable in the next cycle.
- R3: Bits 7..4 and bit 0 of both registers always read zero, including after writes of 0xFF.
- R4: A register write to select 0 clears each flag whose write-data bit is one. Flags whose write-data bit is zero keep their value.
- R5: A pulse on vec_ack[i] clears only the flag of source i. The source index is 0 for overflow, 1 for compare A and 2 for compare B.
- R6: When a flag's set event and a clear of that flag (write or acknowledge) arrive in the same cycle, the flag ends up set.
- R7: irq_req[i] is one exactly when glb_ie, the enable bit of source i and the flag of source i are all one. The request follows these inputs and bits within the same cycle.
- R8: A write to select 1 stores write-data bits 3..1 as the enables of compare B, compare A and overflow. These bits read back at the same positions, and the register resets to zero.
- R9: With pc_mode low, the overflow flag is raised only by a cnt_step while cnt_val is 0xFF. A step at any other count value, or 0xFF without a step, leaves it clear.
- R10: With pc_mode high, the overflow flag is raised only by a cnt_step with cnt_down high while cnt_val is 0x01. A step at 0xFF while counting up (the turn-around) leaves it clear, and so does any other down step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 1 | Register select: 0 flags, 1 enables |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| glb_ie | input | 1 | Global interrupt enable |
| cnt_val | input | 8 | Current timer count |
| cnt_step | input | 1 | Counter advances this cycle |
| cnt_down | input | 1 | Counter direction is down |
| pc_mode | input | 1 | Phase-correct waveform mode |
| cmpa_hit | input | 1 | Compare A match pulse |
| cmpb_hit | input | 1 | Compare B match pulse |
| vec_ack | input | 3 | Per-source vector acknowledge (0 ovf, 1 A, 2 B) |
| irq_req | output | 3 | Per-source interrupt request (0 ovf, 1 A, 2 B) |

## Verification
The flags are driven by single events, by clear writes with mixed one and zero
bits, by per-source acknowledges, and by set and clear in the same cycle. This
separates a write-one-clears register from a plain writable one, and it shows
whether the clear priority is wrong. The request outputs are swept over the
global enable and over enable masks with a single bit set, which exposes a
missing gate term or a swapped source. The overflow detector receives the same
count values in both waveform modes (the top value, the value one above zero,
middle values, and a top value without a step), so a detector that ignores the
mode fails.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
   localparam int NSRC     = 3;
   localparam int SRC_OVF  = 0;
   localparam int SRC_CMPA = 1;
   localparam int SRC_CMPB = 2;
   // register bit of source i is i + FLAG_LSB
   localparam int FLAG_LSB = 1;

   typedef enum logic {
      SEL_FLAG = 1'b0,
      SEL_MASK = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/tmr_ovf_detect.sv
module tmr_ovf_detect #(
   parameter int CNT_W      = 8,
   parameter bit PC_MODE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             step_i,
   input  logic             down_i,
   input  logic             pc_mode_i,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] TOP_VAL  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] NEAR_BOT = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("tmr_ovf_detect: CNT_W must be at least 2");
   end

   logic wrap_up;
   assign wrap_up = step_i && !down_i && (cnt_i == TOP_VAL);

   if (PC_MODE_EN) begin : g_pc
      logic land_bot;
      assign land_bot = step_i && down_i && (cnt_i == NEAR_BOT);
      assign ovf_o    = pc_mode_i ? land_bot : wrap_up;

      AST_PC_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (pc_mode_i && !down_i) |-> !ovf_o); // R10
   end else begin : g_up_only
      assign ovf_o = wrap_up;
   end

   AST_NORM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_mode_i && step_i && !down_i && cnt_i == TOP_VAL) |-> ovf_o); // R9
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wclr_i,
   input  logic ack_i,
   output logic flag_o
);
   logic flag_q;
   logic clr;

   assign clr = wclr_i || ack_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set_i)
         flag_q <= 1'b1;
      else if (clr)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q); // R6
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !set_i) |=> !flag_q); // R5
   AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wclr_i && !set_i) |=> !flag_q); // R4
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !wclr_i && !ack_i) |=> $stable(flag_q)); // R4
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 8,
   parameter bit PC_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              glb_ie,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              cnt_step,
   input  logic              cnt_down,
   input  logic              pc_mode,
   input  logic              cmpa_hit,
   input  logic              cmpb_hit,
   input  logic [2:0]        vec_ack,
   output logic [2:0]        irq_req
);
   import tmr_irq_pkg::*;

   localparam logic [DATA_W-1:0] USED_BITS = DATA_W'(((1 << NSRC) - 1) << FLAG_LSB);

   if (DATA_W < FLAG_LSB + NSRC) begin : g_bad_data
      $error("tmr_irq_ctrl: DATA_W too narrow for the flag field");
   end

   reg_sel_e          sel;
   logic              wr_flag;
   logic              wr_mask;
   logic [NSRC-1:0]   set_vec;
   logic [NSRC-1:0]   flag_vec;
   logic [NSRC-1:0]   mask_q;
   logic              ovf_evt;
   logic              unused_wbits;

   assign sel          = reg_sel_e'(reg_addr);
   assign wr_flag      = reg_we && (sel == SEL_FLAG);
   assign wr_mask      = reg_we && (sel == SEL_MASK);
   assign unused_wbits = ^(reg_wdata & ~USED_BITS);

   tmr_ovf_detect #(
      .CNT_W      (CNT_W),
      .PC_MODE_EN (PC_MODE_EN)
   ) u_ovf (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_i     (cnt_val),
      .step_i    (cnt_step),
      .down_i    (cnt_down),
      .pc_mode_i (pc_mode),
      .ovf_o     (ovf_evt)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[SRC_OVF]  = ovf_evt;
      set_vec[SRC_CMPA] = cmpa_hit;
      set_vec[SRC_CMPB] = cmpb_hit;
   end

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
      tmr_irq_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_vec[gi]),
         .wclr_i (wr_flag && reg_wdata[gi + FLAG_LSB]),
         .ack_i  (vec_ack[gi]),
         .flag_o (flag_vec[gi])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (wr_mask)
         mask_q <= reg_wdata[FLAG_LSB +: NSRC];
   end

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_FLAG: reg_rdata[FLAG_LSB +: NSRC] = flag_vec;
         SEL_MASK: reg_rdata[FLAG_LSB +: NSRC] = mask_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign irq_req = glb_ie ? (mask_q & flag_vec) : '0;

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~USED_BITS) == '0); // R3
   AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_req) |-> glb_ie); // R7
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mask |=> $stable(mask_q)); // R8
endmodule

// File: tb/tmr_irq_ctrl_test.sv
module tmr_irq_ctrl_test;
   localparam time CLK_P = 10ns;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       reg_addr;
   logic       reg_we;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic       glb_ie;
   logic [7:0] cnt_val;
   logic       cnt_step;
   logic       cnt_down;
   logic       pc_mode;
   logic       cmpa_hit;
   logic       cmpb_hit;
   logic [2:0] vec_ack;
   logic [2:0] irq_req;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   tmr_irq_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .glb_ie    (glb_ie),
      .cnt_val   (cnt_val),
      .cnt_step  (cnt_step),
      .cnt_down  (cnt_down),
      .pc_mode   (pc_mode),
      .cmpa_hit  (cmpa_hit),
      .cmpb_hit  (cmpb_hit),
      .vec_ack   (vec_ack),
      .irq_req   (irq_req)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic idle();
      reg_we = 1'b0; reg_wdata = '0; cnt_step = 1'b0; cnt_down = 1'b0;
      cmpa_hit = 1'b0; cmpb_hit = 1'b0; vec_ack = '0; cnt_val = 8'h40;
   endtask

   // inputs already set just after a falling edge; hold across one rising edge
   task automatic cyc();
      @(negedge clk);
      idle();
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      reg_addr = a; reg_we = 1'b1; reg_wdata = d;
      cyc();
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(1'b0, v); chk("R1 flags", v, 8'h00);
      rd(1'b1, v); chk("R1 enables", v, 8'h00);
      chk("R1 irq", {5'b0, irq_req}, 8'h00);
   endtask

   task automatic t_positions();
      logic [7:0] v;
      cmpa_hit = 1'b1; cyc();
      rd(1'b0, v); chk("R2 cmpA bit2", v, 8'h04);
      cmpb_hit = 1'b1; cyc();
      rd(1'b0, v); chk("R2 cmpB bit3", v, 8'h0C);
      pc_mode = 1'b0; cnt_val = 8'hFF; cnt_step = 1'b1; cyc();
      rd(1'b0, v); chk("R2 ovf bit1", v, 8'h0E);
   endtask

   task automatic t_write_clear();
      logic [7:0] v;
      wr(1'b0, 8'h00);
      rd(1'b0, v); chk("R4 write zero keeps", v, 8'h0E);
      wr(1'b0, 8'h04);
      rd(1'b0, v); chk("R4 clear cmpA only", v, 8'h0A);
      wr(1'b0, 8'hFF);
      rd(1'b0, v); chk("R4 R3 clear all, reserved zero", v, 8'h00);
   endtask

   task automatic t_ack();
      logic [7:0] v;
      cmpa_hit = 1'b1; cmpb_hit = 1'b1; cnt_val = 8'hFF; cnt_step = 1'b1; cyc();
      vec_ack = 3'b010; cyc();
      rd(1'b0, v); chk("R5 ack cmpA", v, 8'h0A);
      vec_ack = 3'b001; cyc();
      rd(1'b0, v); chk("R5 ack ovf", v, 8'h08);
      vec_ack = 3'b100; cyc();
      rd(1'b0, v); chk("R5 ack cmpB", v, 8'h00);
   endtask

   task automatic t_race();
      logic [7:0] v;
      cmpb_hit = 1'b1; cyc();
      cmpb_hit = 1'b1; reg_addr = 1'b0; reg_we = 1'b1; reg_wdata = 8'h08; cyc();
      rd(1'b0, v); chk("R6 set beats write clear", v, 8'h08);
      cmpb_hit = 1'b1; vec_ack = 3'b100; cyc();
      rd(1'b0, v); chk("R6 set beats ack", v, 8'h08);
      cmpa_hit = 1'b1; vec_ack = 3'b010; cyc();
      rd(1'b0, v); chk("R6 set beats ack from clear", v, 8'h0C);
      wr(1'b0, 8'hFF);
   endtask

   task automatic t_mask();
      logic [7:0] v;
      wr(1'b1, 8'hFF);
      rd(1'b1, v); chk("R8 R3 enables all", v, 8'h0E);
      wr(1'b1, 8'h04);
      rd(1'b1, v); chk("R8 enable cmpA", v, 8'h04);
   endtask

   task automatic t_irq();
      cmpa_hit = 1'b1; cmpb_hit = 1'b1; cnt_val = 8'hFF; cnt_step = 1'b1; cyc();
      glb_ie = 1'b0; wr(1'b1, 8'h0E);
      #1; chk("R7 global off", {5'b0, irq_req}, 8'h00);
      glb_ie = 1'b1; #1;
      chk("R7 all on", {5'b0, irq_req}, 8'h07);
      wr(1'b1, 8'h08); #1;
      chk("R7 only cmpB enabled", {5'b0, irq_req}, 8'h04);
      wr(1'b1, 8'h02); #1;
      chk("R7 only ovf enabled", {5'b0, irq_req}, 8'h01);
      wr(1'b0, 8'h02); #1;
      chk("R7 flag cleared drops request", {5'b0, irq_req}, 8'h00);
      glb_ie = 1'b0;
      wr(1'b0, 8'hFF); wr(1'b1, 8'h00);
   endtask

   task automatic t_ovf_normal();
      logic [7:0] v;
      pc_mode = 1'b0;
      cnt_val = 8'h80; cnt_step = 1'b1; cyc();
      cnt_val = 8'hFF; cnt_step = 1'b0; cyc();
      cnt_val = 8'h01; cnt_step = 1'b1; cyc();
      rd(1'b0, v); chk("R9 no wrap, no flag", v, 8'h00);
      cnt_val = 8'hFF; cnt_step = 1'b1; cyc();
      rd(1'b0, v); chk("R9 wrap sets flag", v, 8'h02);
      wr(1'b0, 8'h02);
   endtask

   task automatic t_ovf_pc();
      logic [7:0] v;
      pc_mode = 1'b1;
      cnt_val = 8'hFF; cnt_step = 1'b1; cnt_down = 1'b0; cyc();
      rd(1'b0, v); chk("R10 top turn-around quiet", v, 8'h00);
      cnt_val = 8'h05; cnt_step = 1'b1; cnt_down = 1'b1; cyc();
      cnt_val = 8'h00; cnt_step = 1'b1; cnt_down = 1'b0; cyc();
      rd(1'b0, v); chk("R10 other steps quiet", v, 8'h00);
      cnt_val = 8'h01; cnt_step = 1'b1; cnt_down = 1'b1; cyc();
      rd(1'b0, v); chk("R10 bottom sets flag", v, 8'h02);
      wr(1'b0, 8'h02);
      pc_mode = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; reg_addr = 1'b0; glb_ie = 1'b0; pc_mode = 1'b0;
      idle();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_positions();
      t_write_clear();
      t_ack();
      t_race();
      t_mask();
      t_irq();
      t_ovf_normal();
      t_ovf_pc();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule